// File: doc/BRIEF.md
# Priority Bus Arbiter with CPU Run Level

This block is the central arbiter of a backplane bus. Devices ask for the bus on one non-processor (direct memory access) request line and on four interrupt request lines of levels 4 to 7. The arbiter answers with one grant line per request. It watches the shared selection-acknowledge line and compares interrupt levels against the CPU's current 3-bit run level. It also raises a flag that tells the CPU a device owns, or is about to own, the data section of the bus.

A direct memory access request always wins over interrupts. An interrupt is granted only when its level is above the CPU run level. Once a grant is issued, it is frozen until a device acknowledges it. If no device acknowledges within a timeout, the grant is withdrawn. Every decision is registered, so a grant appears one clock after the request that causes it. A synchronous reset, driven from the bus initialise signal, clears all state.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, all grants and `dev_busy` are low after that edge, and the timeout is cleared.
- R2: With `sack` low, no grant outstanding and `npr_req` high, `npg` is high after the next clock edge, whatever `br_req` and `cpu_level` hold.
- R3: With no non-processor request, `br_req` bit i stands for interrupt level i+4. When several bits are set, only the highest level is considered.
- R4: The selected interrupt level L is granted on `bg` bit L-4, one clock later, only if L is strictly greater than `cpu_level`. Otherwise no grant is issued.
- R5: While a grant is outstanding and `sack` is low, no request changes which grant line is high.
- R6: A clock edge with `sack` high drops all grants and sets `dev_busy`. `dev_busy` then stays high after `sack` falls.
- R7: Each grant starts a timeout of `TIMEOUT_CYCLES` clocks. The grant edge counts as cycle 0. If `sack` and all requests are low at the edge TIMEOUT_CYCLES clocks after the grant, or at any later edge, the grant is withdrawn and `dev_busy` is cleared. The grant is kept as long as any request stays high.
- R8: At most one of `npg` and `bg[3:0]` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (bus initialise) |
| npr_req | input | 1 | Non-processor bus request (wired OR of devices) |
| br_req | input | 4 | Interrupt requests, bit i is level i+4 |
| sack | input | 1 | Selection acknowledge from the granted device |
| cpu_level | input | 3 | Current CPU run level 0 to 7 |
| npg | output | 1 | Non-processor grant |
| bg | output | 4 | Interrupt grants, bit i is level i+4 |
| dev_busy | output | 1 | A device owns or is taking the data section |

## Verification
The bench sweeps every interrupt request pattern against every CPU level and computes the expected grant arithmetically. An arbiter that compares with greater-or-equal would grant BR5 at level 5. One that picks the lowest set bit would grant the wrong line. A non-processor request is raised together with BR7 to show that the wrong priority order would grant `bg[3]`. Further requests are raised during an outstanding grant, and a design that re-arbitrates would move the grant. The timeout is probed one clock before and at expiry, and again with a request still held. An off-by-one counter would drop the grant early or late, and ignoring held requests would withdraw it while a device still asks. The bench also checks that an acknowledge leaves `dev_busy` set until a timeout or a reset clears it.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int CLK_HZ         = 200_000_000,
  parameter int TIMEOUT_CYCLES = CLK_HZ / 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       npr_req,
  input  logic [3:0] br_req,
  input  logic       sack,
  input  logic [2:0] cpu_level,
  output logic       npg,
  output logic [3:0] bg,
  output logic       dev_busy
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(TIMEOUT_CYCLES - 1);

  logic [4:0]    grant_q;
  logic [TW-1:0] timer_q;
  logic          busy_q;
  logic [1:0]    top_idx;
  logic [2:0]    top_lvl;
  logic          br_ok;

  always_comb begin
    top_idx = 2'd0;
    for (int i = 0; i < 4; i++)
      if (br_req[i]) top_idx = 2'(i);
  end

  assign top_lvl = 3'd4 + {1'b0, top_idx};
  assign br_ok   = (br_req != 4'd0) && (top_lvl > cpu_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      timer_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (timer_q != '0) timer_q <= timer_q - 1'b1;
      if (sack) begin
        grant_q <= '0;
        busy_q  <= 1'b1;
        timer_q <= '0;
      end else if (npr_req) begin
        if (grant_q == '0) begin
          grant_q <= 5'b10000;
          timer_q <= LOAD;
        end
      end else if (br_req != 4'd0) begin
        if (grant_q == '0 && br_ok) begin
          grant_q <= {1'b0, 4'(1) << top_idx};
          timer_q <= LOAD;
        end
      end else if (grant_q != '0 && timer_q == '0) begin
        grant_q <= '0;
        busy_q  <= 1'b0;
      end
    end
  end

  assign npg      = grant_q[4];
  assign bg       = grant_q[3:0];
  assign dev_busy = busy_q;

  // R6
  sack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sack |=> ({npg, bg} == 5'd0 && dev_busy));

  // R2
  npr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (npr_req && !sack && {npg, bg} == 5'd0) |=> npg);

  // R5
  grant_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ({npg, bg} != 5'd0 && !sack) |=> ({npg, bg} == 5'd0 || {npg, bg} == $past({npg, bg})));

  // R4
  low_br_refused_chk: assert property (@(posedge clk) disable iff (rst)
    ({npg, bg} == 5'd0 && !sack && !npr_req && br_req == 4'b0001 && cpu_level >= 3'd4) |=> ({npg, bg} == 5'd0));

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({npg, bg}));
endmodule

// File: tb/tb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_bus_arbiter;
  localparam int T = 8;
  logic clk = 1'b0, rst = 1'b1, npr_req = 1'b0, sack = 1'b0;
  logic [3:0] br_req = '0;
  logic [2:0] cpu_level = '0;
  logic npg, dev_busy;
  logic [3:0] bg;
  int checks = 0, errors = 0;
  bit done = 0;

  bus_arbiter #(.TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rst(rst), .npr_req(npr_req), .br_req(br_req), .sack(sack),
    .cpu_level(cpu_level), .npg(npg), .bg(bg), .dev_busy(dev_busy));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if ({dev_busy, npg, bg} !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, {dev_busy, npg, bg}, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; npr_req = 0; br_req = 0; sack = 0; cpu_level = 0;
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 reset state", 6'b0);

    // R3 R4 sweep of all patterns and levels
    for (int c = 0; c < 8; c++)
      for (int b = 1; b < 16; b++) begin
        logic [5:0] e;
        int h;
        do_reset();
        h = 0;
        for (int i = 0; i < 4; i++) if (b[i]) h = i;
        e = (h + 4 > c) ? 6'(1 << h) : 6'd0;
        cpu_level = 3'(c); br_req = 4'(b);
        step(1);
        chk($sformatf("R3 R4 br=%0d cpu=%0d", b, c), e);
      end

    // R4 BR5 at level 5 refused, level 4 granted
    do_reset(); cpu_level = 5; br_req = 4'b0010; step(1);
    chk("R4 BR5 at level 5", 6'b0);
    do_reset(); cpu_level = 4; br_req = 4'b0010; step(1);
    chk("R4 BR5 at level 4", 6'b000010);

    // R2 NPR preempts BR7
    do_reset(); cpu_level = 0; br_req = 4'b1000; npr_req = 1; step(1);
    chk("R2 NPR with BR7", 6'b010000);
    do_reset(); cpu_level = 7; npr_req = 1; step(1);
    chk("R2 NPR at level 7", 6'b010000);

    // R5 lock
    do_reset(); br_req = 4'b0001; step(1);
    chk("R5 initial BR4", 6'b000001);
    br_req = 4'b1001; npr_req = 1; step(3);
    chk("R5 grant locked", 6'b000001);

    // R6 sack
    sack = 1; npr_req = 0; br_req = 0; step(1);
    chk("R6 sack clears grants", 6'b100000);
    sack = 0; step(2);
    chk("R6 busy held", 6'b100000);

    // R7 timeout clears busy
    br_req = 4'b0100; step(1);
    chk("R7 new grant while busy", 6'b100100);
    br_req = 0; step(T - 1);
    chk("R7 grant before expiry", 6'b100100);
    step(1);
    chk("R7 grant withdrawn", 6'b0);

    // R7 held request keeps grant
    do_reset(); br_req = 4'b0001; step(1);
    step(T + 3);
    chk("R7 held request keeps grant", 6'b000001);
    br_req = 0; step(1);
    chk("R7 withdraw after release", 6'b0);

    // R1 reset mid grant
    br_req = 4'b1000; step(1);
    chk("R1 pre reset grant", 6'b001000);
    rst = 1; step(1);
    chk("R1 reset clears grant", 6'b0);
    rst = 0; br_req = 0;

    // R8 sampled continuously in watcher
    step(2);
    done = 1;
  end

  always @(negedge clk) if (!rst && !done) begin
    if ($countones({npg, bg}) > 1) begin
      checks++; errors++;
      $display("FAIL R8 actual=%b expected=onehot0", {npg, bg});
    end
  end

  initial begin
    fork
      wait (done);
      begin #500000; errors++; $display("FAIL watchdog actual=timeout expected=finish"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule